// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarm

This block keeps wall-clock time and a calendar: seconds, minutes, hours, day-of-week, day-of-month, month, year and century. Time advances on a synchronous tick-enable input. A select bit says whether each tick comes from a 32.768 kHz crystal or from a 50 Hz / 60 Hz mains line, and a second bit picks 50 or 60. A prescaler turns the selected tick stream into one-second events. Each one-second event starts a carry state machine that updates one field per clock cycle and stops at the first field that does not wrap.

Software reaches every field through a flat register interface: an address, a write strobe, write data and combinational read data. Four alarm compare registers cover seconds, minutes, hours and day-of-week, and each has its own enable. After every one-second update, the alarm stage compares the new time with the enabled fields. A match sets a sticky flag, which drives the interrupt output. Writing 1 to the flag clears it.

The carry state machine has these states:
- `ST_IDLE`: waits for a one-second event, then goes to `ST_SEC`.
- `ST_SEC`, `ST_MIN`, `ST_HOUR`, `ST_DAY`, `ST_MON`, `ST_YEAR`: each updates its own field. If that field wraps, the machine moves on to the next field's state. If it does not wrap, the machine goes to `ST_ALARM`.
- `ST_CENT`: updates the century, then goes to `ST_ALARM`.
- `ST_ALARM`: compares the alarm fields, then returns to `ST_IDLE`.

A software write to any time field sends the machine to `ST_IDLE` from any state.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the fields read as follows: seconds 0, minutes 0, hours 0, day-of-week 1, day-of-month 1, month 1, year 0 and century 20. All alarm registers read 0, the flag reads 0 and `irq` is 0.
- R2: The register addresses are:
  - time fields: 0 seconds, 1 minutes, 2 hours, 3 day-of-week, 4 day-of-month, 5 month, 6 year, 7 century;
  - alarm compare values: 8 seconds, 9 minutes, 10 hours, 11 day-of-week;
  - 12 alarm enables, with bit0 seconds, bit1 minutes, bit2 hours and bit3 day-of-week;
  - 13 status, with bit0 the alarm flag.

  A value written to any of addresses 0 to 12 reads back unchanged.
- R3: With `src_line`=0, seconds advance by one after exactly 32768 ticks, and not after 32767.
- R4: With `src_line`=1, seconds advance by one after 50 ticks when `line_60`=0 and after 60 ticks when `line_60`=1, and not one tick earlier.
- R5: Seconds and minutes wrap from 59 to 0, and hours from 23 to 0. Each wrap carries into the next field.
- R6: Day-of-week counts 1 to 7, wraps from 7 to 1, and advances whenever the day changes.
- R7: Day-of-month wraps to 1 after the last day of the month: 30 for months 4, 6, 9 and 11, 31 for other months, and for month 2 it is 29 when year mod 4 is 0 and 28 otherwise.
- R8: Month wraps from 12 to 1 and carries into year. Year wraps from 99 to 0 and carries into century.
- R9: A write to any time field (addresses 0 to 7) clears the sub-second prescaler, so the next second comes a full period of ticks after the write.
- R10: After each one-second update the alarm fires if at least one enable bit is set and every enabled field equals its compare value. With no enable bit set it never fires.
- R11: The alarm flag is sticky and drives `irq`. Writing status with bit0=1 clears it, and writing bit0=0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One timebase tick per cycle that it is high |
| src_line | input | 1 | 0: crystal tick, 1: mains tick |
| line_60 | input | 1 | In mains mode, 0: 50 Hz, 1: 60 Hz |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for both read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, zero-extended |
| irq | output | 1 | Alarm interrupt, equal to the sticky flag |

## Verification
The in-line assertions check the following on every cycle:
- the seconds step and the 59-to-0 carry;
- the day-of-week wrap and the year-to-century carry;
- the return of the state machine to idle after a time write;
- the prescaler clear and prescaler step;
- that the alarm flag is sticky and rises only in the compare state.

Month lengths, the leap rule, the exact tick counts per second in each timebase, and the enable combinations of the alarm can only be shown by the bench's scenarios. The bench compares readback of all eight fields with its own calendar model.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_SEC, ST_MIN, ST_HOUR, ST_DAY,
        ST_MON, ST_YEAR, ST_CENT, ST_ALARM
    } rtc_state_e;

    localparam logic [3:0] A_SEC     = 4'd0;
    localparam logic [3:0] A_MIN     = 4'd1;
    localparam logic [3:0] A_HOUR    = 4'd2;
    localparam logic [3:0] A_DOW     = 4'd3;
    localparam logic [3:0] A_DOM     = 4'd4;
    localparam logic [3:0] A_MON     = 4'd5;
    localparam logic [3:0] A_YEAR    = 4'd6;
    localparam logic [3:0] A_CENT    = 4'd7;
    localparam logic [3:0] A_AL_SEC  = 4'd8;
    localparam logic [3:0] A_AL_MIN  = 4'd9;
    localparam logic [3:0] A_AL_HOUR = 4'd10;
    localparam logic [3:0] A_AL_DOW  = 4'd11;
    localparam logic [3:0] A_AL_EN   = 4'd12;
    localparam logic [3:0] A_STAT    = 4'd13;

    // Last valid day of a month; leap when the two low year bits are zero.
    function automatic logic [4:0] month_days(input logic [3:0] mon, input logic [6:0] yr);
        case (mon)
            4'd2:                    return (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
            default:                 return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int XTAL_DIV = 32768,
    parameter int LINE_LO  = 50,
    parameter int LINE_HI  = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic src_line,
    input  logic line_60,
    input  logic clear,
    output logic sec_pulse
);
    localparam int MAXDIV = (XTAL_DIV > LINE_HI) ? XTAL_DIV : LINE_HI;
    localparam int CW     = $clog2(MAXDIV);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_m1;
    logic          wrap;

    always_comb begin
        if (src_line) lim_m1 = line_60 ? CW'(LINE_HI - 1) : CW'(LINE_LO - 1);
        else          lim_m1 = CW'(XTAL_DIV - 1);
    end

    assign wrap      = (cnt_q >= lim_m1);
    assign sec_pulse = tick_en && wrap && !clear;

    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clear)   cnt_q <= '0;
        else if (tick_en) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end

    // R9: a time-field write empties the prescaler
    a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> cnt_q == '0);
    // R3/R4: each tick below the limit advances the count by one
    a_r4_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !clear && !wrap) |=> cnt_q == $past(cnt_q) + 1'b1);
    // R3/R4: a second event restarts the sub-second count
    a_r3_pulse_restart: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> cnt_q == '0);

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       check,
    input  logic       clr,
    input  logic [5:0] cur_sec,
    input  logic [5:0] cur_min,
    input  logic [4:0] cur_hour,
    input  logic [2:0] cur_dow,
    input  logic [5:0] cmp_sec,
    input  logic [5:0] cmp_min,
    input  logic [4:0] cmp_hour,
    input  logic [2:0] cmp_dow,
    input  logic [3:0] en,
    output logic       flag
);
    logic [3:0] field_ok;
    logic       match;

    assign field_ok[0] = !en[0] || (cur_sec  == cmp_sec);
    assign field_ok[1] = !en[1] || (cur_min  == cmp_min);
    assign field_ok[2] = !en[2] || (cur_hour == cmp_hour);
    assign field_ok[3] = !en[3] || (cur_dow  == cmp_dow);
    assign match       = (|en) && (&field_ok);

    always_ff @(posedge clk) begin
        if (!rst_n)              flag <= 1'b0;
        else if (check && match) flag <= 1'b1;
        else if (clr)            flag <= 1'b0;
    end

    a_r10_fire_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (check && match) |=> flag);
    a_r10_rise_only_on_check: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !check) |=> !flag);
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !check) |=> !flag);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int XTAL_DIV = 32768,
    parameter int LINE_LO  = 50,
    parameter int LINE_HI  = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       src_line,
    input  logic       line_60,
    input  logic       wr_en,
    input  logic [3:0] addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       irq
);
    rtc_state_e st_q, st_d;

    logic [5:0] sec_q, min_q;
    logic [4:0] hour_q, dom_q;
    logic [2:0] dow_q;
    logic [3:0] mon_q;
    logic [6:0] year_q, cent_q;
    logic [5:0] al_sec_q, al_min_q;
    logic [4:0] al_hour_q;
    logic [2:0] al_dow_q;
    logic [3:0] al_en_q;
    logic       time_wr, flag_clr, sec_pulse, flag;
    logic [4:0] last_day;
    logic       unused_hi;

    assign time_wr   = wr_en && (addr <= A_CENT);
    assign flag_clr  = wr_en && (addr == A_STAT) && wr_data[0];
    assign last_day  = month_days(mon_q, year_q);
    assign unused_hi = wr_data[7];

    rtc_prescaler #(.XTAL_DIV(XTAL_DIV), .LINE_LO(LINE_LO), .LINE_HI(LINE_HI)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .src_line(src_line),
        .line_60(line_60), .clear(time_wr), .sec_pulse(sec_pulse)
    );

    rtc_alarm u_alarm (
        .clk(clk), .rst_n(rst_n), .check(st_q == ST_ALARM), .clr(flag_clr),
        .cur_sec(sec_q), .cur_min(min_q), .cur_hour(hour_q), .cur_dow(dow_q),
        .cmp_sec(al_sec_q), .cmp_min(al_min_q), .cmp_hour(al_hour_q),
        .cmp_dow(al_dow_q), .en(al_en_q), .flag(flag)
    );

    assign irq = flag;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next state: carry ripples one field per cycle
    always_comb begin
        st_d = st_q;
        if (time_wr) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:  if (sec_pulse) st_d = ST_SEC;
                ST_SEC:   st_d = (sec_q  >= 6'd59)   ? ST_MIN  : ST_ALARM;
                ST_MIN:   st_d = (min_q  >= 6'd59)   ? ST_HOUR : ST_ALARM;
                ST_HOUR:  st_d = (hour_q >= 5'd23)   ? ST_DAY  : ST_ALARM;
                ST_DAY:   st_d = (dom_q  >= last_day) ? ST_MON : ST_ALARM;
                ST_MON:   st_d = (mon_q  >= 4'd12)   ? ST_YEAR : ST_ALARM;
                ST_YEAR:  st_d = (year_q >= 7'd99)   ? ST_CENT : ST_ALARM;
                ST_CENT:  st_d = ST_ALARM;
                ST_ALARM: st_d = ST_IDLE;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    // Field updates (outputs of the state machine) and software writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0; min_q <= '0; hour_q <= '0; dow_q <= 3'd1;
            dom_q <= 5'd1; mon_q <= 4'd1; year_q <= '0; cent_q <= 7'd20;
        end else if (time_wr) begin
            case (addr)
                A_SEC:   sec_q  <= wr_data[5:0];
                A_MIN:   min_q  <= wr_data[5:0];
                A_HOUR:  hour_q <= wr_data[4:0];
                A_DOW:   dow_q  <= wr_data[2:0];
                A_DOM:   dom_q  <= wr_data[4:0];
                A_MON:   mon_q  <= wr_data[3:0];
                A_YEAR:  year_q <= wr_data[6:0];
                default: cent_q <= wr_data[6:0];
            endcase
        end else begin
            case (st_q)
                ST_SEC:  sec_q  <= (sec_q  >= 6'd59) ? 6'd0 : sec_q + 6'd1;
                ST_MIN:  min_q  <= (min_q  >= 6'd59) ? 6'd0 : min_q + 6'd1;
                ST_HOUR: hour_q <= (hour_q >= 5'd23) ? 5'd0 : hour_q + 5'd1;
                ST_DAY: begin
                    dow_q <= (dow_q >= 3'd7) ? 3'd1 : dow_q + 3'd1;
                    dom_q <= (dom_q >= last_day) ? 5'd1 : dom_q + 5'd1;
                end
                ST_MON:  mon_q  <= (mon_q  >= 4'd12) ? 4'd1 : mon_q + 4'd1;
                ST_YEAR: year_q <= (year_q >= 7'd99) ? 7'd0 : year_q + 7'd1;
                ST_CENT: cent_q <= (cent_q >= 7'd99) ? 7'd0 : cent_q + 7'd1;
                default: ;
            endcase
        end
    end

    // Alarm registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            al_sec_q <= '0; al_min_q <= '0; al_hour_q <= '0; al_dow_q <= '0; al_en_q <= '0;
        end else if (wr_en) begin
            case (addr)
                A_AL_SEC:  al_sec_q  <= wr_data[5:0];
                A_AL_MIN:  al_min_q  <= wr_data[5:0];
                A_AL_HOUR: al_hour_q <= wr_data[4:0];
                A_AL_DOW:  al_dow_q  <= wr_data[2:0];
                A_AL_EN:   al_en_q   <= wr_data[3:0];
                default: ;
            endcase
        end
    end

    // Read mux
    always_comb begin
        rd_data = '0;
        case (addr)
            A_SEC:     rd_data[5:0] = sec_q;
            A_MIN:     rd_data[5:0] = min_q;
            A_HOUR:    rd_data[4:0] = hour_q;
            A_DOW:     rd_data[2:0] = dow_q;
            A_DOM:     rd_data[4:0] = dom_q;
            A_MON:     rd_data[3:0] = mon_q;
            A_YEAR:    rd_data[6:0] = year_q;
            A_CENT:    rd_data[6:0] = cent_q;
            A_AL_SEC:  rd_data[5:0] = al_sec_q;
            A_AL_MIN:  rd_data[5:0] = al_min_q;
            A_AL_HOUR: rd_data[4:0] = al_hour_q;
            A_AL_DOW:  rd_data[2:0] = al_dow_q;
            A_AL_EN:   rd_data[3:0] = al_en_q;
            A_STAT:    rd_data[0]   = flag;
            default: ;
        endcase
    end

    a_r5_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SEC && sec_q < 6'd59 && !time_wr) |=> sec_q == $past(sec_q) + 6'd1);
    a_r5_sec_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SEC && sec_q >= 6'd59 && !time_wr) |=> (sec_q == 6'd0 && st_q == ST_MIN));
    a_r6_dow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DAY && dow_q == 3'd7 && !time_wr) |=> dow_q == 3'd1);
    a_r8_year_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_YEAR && year_q >= 7'd99 && !time_wr) |=> (year_q == 7'd0 && st_q == ST_CENT));
    a_r9_write_abort: assert property (@(posedge clk) disable iff (!rst_n)
        time_wr |=> st_q == ST_IDLE);

endmodule

// File: tb/sim_rtc_calendar.sv
`timescale 1ns/1ps
module sim_rtc_calendar;
    logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, src_line = 1'b0, line_60 = 1'b0;
    logic wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic irq;

    int n_chk = 0, n_fail = 0;
    int m[8];

    always #5 clk = ~clk;

    rtc_calendar u0 (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .src_line(src_line),
        .line_60(line_60), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq));

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk); wr_en = 1'b1; addr = 4'(a); wr_data = 8'(d);
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk); addr = 4'(a); #1; v = int'(rd_data);
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk); tick_en = 1'b1;
            repeat (n) @(posedge clk);
            #1 tick_en = 1'b0;
        end
        repeat (12) @(posedge clk);
    endtask

    function automatic int dim(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic adv;
        m[0]++;
        if (m[0] > 59) begin
            m[0] = 0; m[1]++;
            if (m[1] > 59) begin
                m[1] = 0; m[2]++;
                if (m[2] > 23) begin
                    m[2] = 0; m[3] = (m[3] == 7) ? 1 : m[3] + 1; m[4]++;
                    if (m[4] > dim(m[5], m[6])) begin
                        m[4] = 1; m[5]++;
                        if (m[5] > 12) begin
                            m[5] = 1; m[6]++;
                            if (m[6] > 99) begin m[6] = 0; m[7] = (m[7] + 1) % 100; end
                        end
                    end
                end
            end
        end
    endtask

    task automatic set_all;
        for (int i = 0; i < 8; i++) wr(i, m[i]);
    endtask

    task automatic cmp_all(input string req);
        int v;
        for (int i = 0; i < 8; i++) begin
            rd(i, v);
            check($sformatf("%s field%0d", req, i), v, m[i]);
        end
    endtask

    task automatic set_time(input int s, input int mi, input int h, input int dw,
                            input int dm, input int mo, input int y, input int c);
        m[0] = s; m[1] = mi; m[2] = h; m[3] = dw; m[4] = dm; m[5] = mo; m[6] = y; m[7] = c;
        set_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int v, lim, k, r;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        m[0] = 0; m[1] = 0; m[2] = 0; m[3] = 1; m[4] = 1; m[5] = 1; m[6] = 0; m[7] = 20;
        cmp_all("R1 reset");
        for (int i = 8; i < 14; i++) begin rd(i, v); check("R1 alarm regs zero", v, 0); end
        check("R1 irq low", int'(irq), 0);

        // R2 readback of every writable register
        set_time(17, 42, 13, 5, 19, 7, 45, 21);
        cmp_all("R2 readback");
        wr(8, 33); wr(9, 12); wr(10, 22); wr(11, 6); wr(12, 9);
        rd(8, v); check("R2 alarm sec", v, 33);
        rd(9, v); check("R2 alarm min", v, 12);
        rd(10, v); check("R2 alarm hour", v, 22);
        rd(11, v); check("R2 alarm dow", v, 6);
        rd(12, v); check("R2 alarm en", v, 9);
        wr(12, 0);

        // R3 crystal timebase
        src_line = 1'b0;
        set_time(10, 0, 0, 1, 1, 1, 0, 20);
        ticks(32767); rd(0, v); check("R3 no step at 32767", v, 10);
        ticks(1);     rd(0, v); check("R3 step at 32768", v, 11);

        // R4 mains timebase, 50 and 60
        src_line = 1'b1; line_60 = 1'b0;
        set_time(20, 0, 0, 1, 1, 1, 0, 20);
        ticks(49); rd(0, v); check("R4 50Hz no step at 49", v, 20);
        ticks(1);  rd(0, v); check("R4 50Hz step at 50", v, 21);
        line_60 = 1'b1;
        set_time(20, 0, 0, 1, 1, 1, 0, 20);
        ticks(59); rd(0, v); check("R4 60Hz no step at 59", v, 20);
        ticks(1);  rd(0, v); check("R4 60Hz step at 60", v, 21);

        // R9 write resets prescaler
        line_60 = 1'b0;
        set_time(5, 0, 0, 1, 1, 1, 0, 20);
        ticks(30); wr(1, 3); ticks(30);
        rd(0, v); check("R9 prescaler cleared by write", v, 5);
        ticks(20); rd(0, v); check("R9 full period after write", v, 6);

        // Directed calendar corners (50 ticks per second)
        set_time(59, 59, 23, 3, 28, 2, 23, 20); ticks(50); adv(); cmp_all("R7 Feb 28 non-leap");
        set_time(59, 59, 23, 4, 28, 2, 24, 20); ticks(50); adv(); cmp_all("R7 Feb 28 leap");
        ticks(86399 * 0); // no-op spacer
        set_time(59, 59, 23, 5, 29, 2, 24, 20); ticks(50); adv(); cmp_all("R7 Feb 29 leap");
        set_time(59, 59, 23, 2, 30, 4, 10, 20); ticks(50); adv(); cmp_all("R7 Apr 30");
        set_time(59, 59, 23, 7, 31, 12, 99, 20); ticks(50); adv(); cmp_all("R8 year and century carry");
        check("R6 dow wrap 7 to 1", m[3], 1);
        set_time(59, 59, 22, 6, 15, 6, 50, 20); ticks(50); adv(); cmp_all("R5 minute and hour carry");

        // Random scenarios mixed across both mains rates
        for (int t = 0; t < 40; t++) begin
            line_60 = 1'($urandom % 2);
            lim = line_60 ? 60 : 50;
            m[5] = 1 + $urandom % 12;
            m[6] = ($urandom % 3 == 0) ? 99 : (($urandom % 2) ? 4 * ($urandom % 25) : $urandom % 100);
            m[4] = ($urandom % 2) ? dim(m[5], m[6]) : 1 + $urandom % dim(m[5], m[6]);
            m[0] = ($urandom % 2) ? 59 : $urandom % 60;
            m[1] = ($urandom % 2) ? 59 : $urandom % 60;
            m[2] = ($urandom % 2) ? 23 : $urandom % 24;
            m[3] = 1 + $urandom % 7;
            m[7] = $urandom % 99;
            set_all();
            k = $urandom % 3; r = $urandom % lim;
            ticks(k * lim + r);
            for (int j = 0; j < k; j++) adv();
            cmp_all("R5 R7 R8 random");
        end

        // R10 and R11 alarm
        line_60 = 1'b0;
        wr(8, 31); wr(9, 20); wr(10, 10); wr(11, 3); wr(12, 1);
        set_time(30, 20, 10, 3, 1, 1, 0, 20); ticks(50);
        check("R10 seconds-only alarm fires", int'(irq), 1);
        rd(13, v); check("R11 status flag set", v, 1);
        wr(13, 0); check("R11 write 0 keeps flag", int'(irq), 1);
        wr(13, 1); check("R11 write 1 clears flag", int'(irq), 0);
        wr(8, 32); wr(9, 21); wr(12, 3);
        set_time(31, 20, 10, 3, 1, 1, 0, 20); ticks(50);
        check("R10 enabled minute mismatch blocks", int'(irq), 0);
        wr(12, 0);
        set_time(31, 21, 10, 3, 1, 1, 0, 20); ticks(50);
        check("R10 no enables never fires", int'(irq), 0);
        wr(8, 41); wr(9, 20); wr(12, 15);
        set_time(40, 20, 10, 3, 1, 1, 0, 20); ticks(50);
        check("R10 all four fields match", int'(irq), 1);
        ticks(50);
        check("R11 flag stays set", int'(irq), 1);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule